// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block receives characters from an asynchronous serial line. It waits in idle for the line to go low and confirms a start bit with a three-sample majority vote in the middle of the bit. It then samples the data bits, LSB first, an optional parity bit, and the first stop bit. All sampling is paced by a 16x oversampling tick that a separate baud generator supplies. A character can be 5, 6, 7, 8 or 9 bits long, set by a 3-bit size code. Parity can be off, even or odd.

When the first stop bit has been sampled, the character goes into a two-entry queue. Its framing, parity and overrun flags go into the same entry. The head entry's character, ninth bit and flags are always visible on the outputs. Reading them has no side effect. A one-cycle `rd_data` strobe pops the head entry, so software reads the status before it takes the data byte. Clearing the receive enable abandons any frame in progress and empties the queue.

Controller states: `ST_IDLE` (line watched for low), `ST_START` (start bit under confirmation), `ST_DATA` (character bits), `ST_PARITY` (parity bit) and `ST_STOP` (first stop bit).

Transitions:
- `ST_IDLE` to `ST_START` on a low line.
- `ST_START` back to `ST_IDLE` if the vote is high. `ST_START` to `ST_DATA` at the end of the bit.
- `ST_DATA` to `ST_PARITY` or `ST_STOP` after the last character bit, depending on whether parity is enabled.
- `ST_PARITY` to `ST_STOP` at the end of the bit.
- `ST_STOP` to `ST_IDLE` at the stop-bit vote.
- Any state to `ST_IDLE` whenever `rx_en` is low.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `rx_avail` is 0 and `rx_data`, `rx_bit8`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: A start bit is accepted only if the majority of oversampling ticks 7, 8 and 9 (counted from 0 at detection) is low. A shorter low pulse returns the receiver to idle and stores nothing.
- R3: Character bits are received LSB first, one per 16 ticks. Size codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b111 select 5, 6, 7, 8 and 9 bits; any other code selects 8. Bits of `rx_data` above the character length read 0.
- R4: With size code 3'b111, the ninth character bit appears on `rx_bit8`. For every other size, `rx_bit8` reads 0.
- R5: When `cfg_par_en` is 1, one parity bit follows the character. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity, both over all character bits. On a mismatch the entry's `err_parity` is 1.
- R6: If the first stop bit samples low, the character is still stored and its `err_frame` is 1.
- R7: A frame is complete at the first stop-bit vote and a second stop bit is never checked. Frames sent back to back with a single stop bit are each received correctly.
- R8: The queue holds two entries. The outputs show the head entry only. They stay unchanged while `rd_data` is low, and a one-cycle `rd_data` pulse removes the head.
- R9: A frame that completes while both entries are occupied is discarded. `err_overrun` is then set on the newest stored entry, and the older entry's `err_overrun` stays 0.
- R10: While `rx_en` is 0, a frame in progress is abandoned and the queue is emptied. Nothing is stored from that frame after `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low aborts and flushes |
| os_tick | input | 1 | One-cycle pulse at 16 times the baud rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_size | input | 3 | Character size code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_data | input | 1 | Pop strobe for the head entry |
| rx_avail | output | 1 | Queue holds at least one entry |
| rx_data | output | 8 | Low 8 bits of the head character |
| rx_bit8 | output | 1 | Ninth bit of the head character |
| err_frame | output | 1 | Head entry framing error |
| err_parity | output | 1 | Head entry parity error |
| err_overrun | output | 1 | Head entry overrun mark |

## Verification
The stop-bit vote falls about ten ticks into the stop bit, counting two synchronizer stages and the start-detection cycle. The new entry is visible one clock after that vote. The bench therefore checks entries only after the whole stop bit plus an idle gap has gone by. A pop or a flush changes the outputs on the clock edge after the strobe or the low enable is sampled, so those checks sample on the second falling edge after the stimulus. A framing-error frame leaves the line low past the vote, so the bench idles for two bit times after each frame, which lets the false start it causes settle first.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       ovr;
        logic       ferr;
        logic       perr;
        logic [8:0] chr;
    } rx_entry_t;

    function automatic logic [3:0] char_len(input logic [2:0] code);
        case (code)
            3'b000:  return 4'd5;
            3'b001:  return 4'd6;
            3'b010:  return 4'd7;
            3'b111:  return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] cfg_size,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       push,
    output rx_entry_t  push_entry,
    output rx_state_e  state
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] SMP_A   = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] SMP_B   = CNT_W'(OS_RATE / 2);
    localparam logic [CNT_W-1:0] SMP_C   = CNT_W'(OS_RATE / 2 + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OS_RATE - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       bit_q;
    logic [1:0]       votes_q;
    logic [8:0]       shr_q;
    logic             par_q;

    logic       samp, decide, bit_end, maj, last_data;
    logic [3:0] len;

    assign len       = char_len(cfg_size);
    assign samp      = tick && (cnt_q == SMP_A || cnt_q == SMP_B);
    assign decide    = tick && (cnt_q == SMP_C);
    assign bit_end   = tick && (cnt_q == CNT_TOP);
    assign maj       = (votes_q[1] & votes_q[0]) | (votes_q[1] & rxd) | (votes_q[0] & rxd);
    assign last_data = (bit_q == len - 4'd1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!rxd) state_d = ST_START;
            ST_START:  begin
                if (decide && maj) state_d = ST_IDLE;
                else if (bit_end)  state_d = ST_DATA;
            end
            ST_DATA:   if (bit_end && last_data) state_d = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (decide) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    // bit timing and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            votes_q <= '0;
            shr_q   <= '0;
            par_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            votes_q <= '0;
            shr_q   <= '0;
            par_q   <= 1'b0;
        end else if (tick) begin
            cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
            if (samp) votes_q <= {votes_q[0], rxd};
            if (decide && state_q == ST_DATA)   shr_q <= shr_q | (9'(maj) << bit_q);
            if (decide && state_q == ST_PARITY) par_q <= maj;
            if (bit_end && state_q == ST_DATA)  bit_q <= bit_q + 4'd1;
        end
    end

    // outputs
    always_comb begin
        push            = en && (state_q == ST_STOP) && decide;
        push_entry.chr  = shr_q;
        push_entry.ferr = !maj;
        push_entry.perr = cfg_par_en && ((^shr_q ^ par_q) != cfg_par_odd);
        push_entry.ovr  = 1'b0;
        state           = state_q;
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  rx_entry_t                 push_entry,
    input  logic                      pop,
    output rx_entry_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rx_entry_t     mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q, newest;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop, ovr_set;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign ovr_set = push && full;
    assign do_pop  = pop && (cnt_q != '0);
    assign newest  = (wr_q == '0) ? LAST : wr_q - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= push_entry;
                wr_q        <= inc(wr_q);
            end
            if (ovr_set) mem_q[newest].ovr <= 1'b1;
            if (do_pop)  rd_q <= inc(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head  = mem_q[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE    = 16,
    parameter int FIFO_DEPTH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [2:0] cfg_size,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_data,
    output logic       rx_avail,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic          rxd_s, push;
    rx_entry_t     push_entry, head;
    rx_state_e     fsm_state;
    logic [CW-1:0] fifo_count;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    uart_rx_fsm #(.OS_RATE(OS_RATE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rxd(rxd_s),
        .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .push(push), .push_entry(push_entry), .state(fsm_state)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push),
        .push_entry(push_entry), .pop(rd_data), .head(head), .count(fifo_count)
    );

    always_comb begin
        rx_avail    = (fifo_count != '0);
        rx_data     = rx_avail ? head.chr[7:0] : 8'h00;
        rx_bit8     = rx_avail && head.chr[8];
        err_frame   = rx_avail && head.ferr;
        err_parity  = rx_avail && head.perr;
        err_overrun = rx_avail && head.ovr;
    end
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic                       rd_data,
    input logic                       rx_avail,
    input logic [7:0]                 rx_data,
    input logic                       rx_bit8,
    input logic                       err_frame,
    input logic                       err_parity,
    input logic                       err_overrun,
    input rx_state_e                  fsm_state,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_avail); // R10

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> fsm_state == ST_IDLE); // R10

    AST_ENTRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !rd_data && rx_en |=> rx_avail); // R8

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !rd_data && rx_en |=> $stable(rx_data) && $stable(rx_bit8)
            && $stable(err_frame) && $stable(err_parity) && $stable(err_overrun)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH)); // R9
endmodule

bind uart_rx_tagged uart_rx_tagged_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_data(rd_data),
    .rx_avail(rx_avail), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .fsm_state(fsm_state), .fifo_count(fifo_count)
);

// File: tb/sim_uart_rx_tagged.sv
module sim_uart_rx_tagged;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int GAP_CLKS   = 2 * BIT_CLKS;
    localparam int WATCHDOG   = 150000;
    localparam int NV         = 8;
    // [8:0] char, [11:9] size code, [12] parity on, [13] odd, [14] low stop, [15] corrupt parity
    localparam logic [15:0] VEC [NV] = '{
        16'h0655, 16'h00A3, 16'h1FC5, 16'h96F0,
        16'h36B7, 16'hB47E, 16'h473C, 16'h032D
    };

    logic       clk = 0, rst_n = 0, rx_en = 0, os_tick = 0, rxd = 1;
    logic [2:0] cfg_size = 3'b011;
    logic       cfg_par_en = 0, cfg_par_odd = 0, rd_data = 0;
    logic       rx_avail, rx_bit8, err_frame, err_parity, err_overrun;
    logic [7:0] rx_data;
    int checks = 0, fails = 0, tdiv = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    uart_rx_tagged u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_data(rd_data), .rx_avail(rx_avail), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'b000: return 5;
            3'b001: return 6;
            3'b010: return 7;
            3'b111: return 9;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] c, input int len, input logic par_en,
                              input logic odd, input logic flip, input logic stop, input int gap);
        logic [8:0] m;
        m = c & 9'((1 << len) - 1);
        send_bit(1'b0);
        for (int i = 0; i < len; i++) send_bit(m[i]);
        if (par_en) send_bit(^m ^ odd ^ flip);
        send_bit(stop);
        rxd = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pop;
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] status();
        return {11'd0, rx_avail, err_overrun, err_frame, err_parity, rx_bit8};
    endfunction

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 avail", 16'(rx_avail), 16'h0);
        chk("R1 data", 16'(rx_data), 16'h0);
        chk("R1 flags", status(), 16'h0);
        rst_n = 1;
        @(negedge clk);
        rx_en = 1;
        repeat (BIT_CLKS) @(negedge clk);

        // vector table: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [15:0] w;
            int          len;
            logic [8:0]  m;
            w   = VEC[v];
            len = len_of(w[11:9]);
            m   = w[8:0] & 9'((1 << len) - 1);
            cfg_size = w[11:9]; cfg_par_en = w[12]; cfg_par_odd = w[13];
            @(negedge clk);
            send_frame(w[8:0], len, w[12], w[13], w[15], !w[14], GAP_CLKS);
            chk($sformatf("R3 vec%0d data", v), 16'(rx_data), 16'(m[7:0]));
            chk($sformatf("R4 vec%0d bit8", v), 16'(rx_bit8), 16'(m[8]));
            chk($sformatf("R5 vec%0d parity", v), 16'(err_parity), 16'(w[12] & w[15]));
            chk($sformatf("R6 vec%0d frame", v), 16'(err_frame), 16'(w[14]));
            pop();
            chk($sformatf("R8 vec%0d popped", v), 16'(rx_avail), 16'h0);
        end
        cfg_size = 3'b011; cfg_par_en = 0; cfg_par_odd = 0;

        // R2: short low glitch
        rxd = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (GAP_CLKS) @(negedge clk);
        chk("R2 glitch ignored", 16'(rx_avail), 16'h0);

        // R7: back to back, single stop bit, no gap
        send_frame(9'h0E1, 8, 0, 0, 0, 1, 0);
        send_frame(9'h07F, 8, 0, 0, 0, 1, GAP_CLKS);
        chk("R7 first", 16'(rx_data), 16'h00E1);
        pop();
        chk("R7 second", 16'(rx_data), 16'h007F);
        chk("R7 second flags", status(), 16'h0010);
        pop();

        // R9: three frames with no reads
        send_frame(9'h011, 8, 0, 0, 0, 1, GAP_CLKS);
        send_frame(9'h022, 8, 0, 0, 0, 1, GAP_CLKS);
        send_frame(9'h033, 8, 0, 0, 0, 1, GAP_CLKS);
        chk("R9 oldest data", 16'(rx_data), 16'h0011);
        chk("R9 oldest no ovr", 16'(err_overrun), 16'h0);
        repeat (20) @(negedge clk);
        chk("R8 status reread", status(), 16'h0010);
        chk("R8 data reread", 16'(rx_data), 16'h0011);
        pop();
        chk("R9 newest data", 16'(rx_data), 16'h0022);
        chk("R9 newest ovr", 16'(err_overrun), 16'h1);
        pop();
        chk("R9 discarded", 16'(rx_avail), 16'h0);

        // R10: flush stored entry and abort frame in progress
        send_frame(9'h05A, 8, 0, 0, 0, 1, GAP_CLKS);
        chk("R10 stored", 16'(rx_avail), 16'h1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 flushed", 16'(rx_avail), 16'h0);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        rx_en = 1'b1;
        repeat (GAP_CLKS) @(negedge clk);
        chk("R10 nothing after abort", 16'(rx_avail), 16'h0);
        send_frame(9'h0C3, 8, 0, 0, 0, 1, GAP_CLKS);
        chk("R10 resumes", 16'(rx_data), 16'h00C3);
        pop();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule